// File: doc/BRIEF.md
# Packed Lane Multiplier with Byte SAD

This block is a pipelined arithmetic unit for 64-bit packed operands. Each accepted transfer carries two 64-bit operands and a 3-bit operation code. Four 16x16 lane multipliers are shared by three product modes: low half, signed high half and unsigned high half. The same multipliers serve a pairwise signed multiply-add that folds adjacent products into two 32-bit sums. A separate byte path forms the sum of absolute differences over eight unsigned byte pairs.

The result leaves the block two clock edges after acceptance. Both edges of the block are valid/ready streams. The pipeline moves as one unit: it advances whenever the output register is empty or the consumer takes its word. `in_ready` is exactly this advance condition. When the consumer holds `out_ready` low while a result is waiting, the result and `out_valid` stay frozen, and `in_ready` drops so that no new operand pair is taken. While `out_ready` stays high, one operand pair is accepted on every clock with no bubbles.

Top module: `pmul_sad_unit`

## Requirements
- R1: Operation code 0 multiplies each of the four 16-bit lane pairs. For each lane, it returns bits [15:0] of the product in the same lane.
- R2: Operation code 1 returns bits [31:16] of each signed 16x16 lane product in the same lane.
- R3: Operation code 2 returns bits [31:16] of each lane product, with both factors taken as unsigned.
- R4: Operation code 3 forms four signed lane products. Bits [31:0] of the result hold lane0+lane1 and bits [63:32] hold lane2+lane3, each sum wrapping modulo 2^32 with no saturation. For example, all lanes at -32768 give 0x80000000 in each half.
- R5: Operation code 4 places the sum of the unsigned absolute differences of all eight byte pairs in bits [10:0], and every higher result bit is zero. The largest possible total is 2040.
- R6: Operation codes 5, 6 and 7 produce an all-zero result.
- R7: A transfer accepted at one clock edge is presented on `out_valid`/`out_data` after the second edge. With `out_ready` high, a new pair is accepted every cycle and results leave in order.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold their values and `in_ready` is low.
- R9: While reset is asserted and after it is released, `out_valid` is low until the first result arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Unit takes the pair at this edge |
| in_op | input | 3 | Operation code |
| in_a | input | 64 | First packed operand |
| in_b | input | 64 | Second packed operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Packed result |

## Verification
Two events can fall in the same cycle: a stall, where the consumer refuses a waiting result, and the arrival of a new operand pair at the input. The bench drives `in_valid` and `out_ready` at random, with operation codes mixed, so that stalls land both with a pair offered and with the pipeline half full. Outputs are checked in order against a behavioural queue model. A held result must not change, and `in_ready` must stay low for as long as the stall lasts, so that no pair is lost or duplicated when the pipeline resumes.

// File: rtl/pms_pkg.sv
package pms_pkg;
  localparam int LANES   = 4;
  localparam int LANE_W  = 16;
  localparam int DATA_W  = LANES * LANE_W;
  localparam int BYTES   = DATA_W / 8;
  localparam int PROD_W  = 2 * LANE_W + 2;
  localparam int SAD_W   = 8 + $clog2(BYTES);

  typedef enum logic [2:0] {
    OP_LOW  = 3'd0,
    OP_HIS  = 3'd1,
    OP_HIU  = 3'd2,
    OP_MADD = 3'd3,
    OP_SAD  = 3'd4
  } pm_op_e;
endpackage

// File: rtl/lane_mul.sv
module lane_mul #(
  parameter int W = 16
) (
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic             sgn,
  output logic [2*W+1:0]   prod
);
  logic signed [W:0]     ax, bx;
  logic signed [2*W+1:0] p;
  always_comb begin
    ax = $signed({sgn & a[W-1], a});
    bx = $signed({sgn & b[W-1], b});
    p  = ax * bx;
    prod = p;
  end
endmodule

// File: rtl/sad_absdiff.sv
module sad_absdiff #(
  parameter int NB = 8
) (
  input  logic [NB*8-1:0] a,
  input  logic [NB*8-1:0] b,
  output logic [NB*8-1:0] diffs
);
  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic [7:0] x, y;
    assign x = a[i*8 +: 8];
    assign y = b[i*8 +: 8];
    assign diffs[i*8 +: 8] = (x >= y) ? (x - y) : (y - x);
  end
endmodule

// File: rtl/sad_sum.sv
module sad_sum #(
  parameter int NB = 8,
  parameter int SW = 11
) (
  input  logic [NB*8-1:0] diffs,
  output logic [SW-1:0]   total
);
  always_comb begin
    total = '0;
    for (int i = 0; i < NB; i++)
      total = total + SW'(diffs[i*8 +: 8]);
  end
endmodule

// File: rtl/pmul_sad_unit.sv
module pmul_sad_unit
  import pms_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [2:0]  in_op,
  input  logic [63:0] in_a,
  input  logic [63:0] in_b,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [63:0] out_data
);
  logic advance;
  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  // stage 1 combinational: products and byte differences
  logic              use_signed;
  logic [PROD_W-1:0] prod_c [LANES];
  logic [DATA_W-1:0] diff_c;
  assign use_signed = (in_op != OP_HIU);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    lane_mul #(.W(LANE_W)) u_mul (
      .a   (in_a[i*LANE_W +: LANE_W]),
      .b   (in_b[i*LANE_W +: LANE_W]),
      .sgn (use_signed),
      .prod(prod_c[i])
    );
  end

  sad_absdiff #(.NB(BYTES)) u_absd (.a(in_a), .b(in_b), .diffs(diff_c));

  // stage 1 registers
  logic              s1_valid;
  logic [2:0]        s1_op;
  logic [PROD_W-1:0] s1_prod [LANES];
  logic [DATA_W-1:0] s1_diff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
    end else if (advance) begin
      s1_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (advance && in_valid) begin
      s1_op   <= in_op;
      s1_diff <= diff_c;
      for (int i = 0; i < LANES; i++) s1_prod[i] <= prod_c[i];
    end
  end

  // stage 2 combinational: selection and summation
  logic [SAD_W-1:0]  sad_total;
  logic [DATA_W-1:0] res_c;

  sad_sum #(.NB(BYTES), .SW(SAD_W)) u_sum (.diffs(s1_diff), .total(sad_total));

  always_comb begin
    res_c = '0;
    case (s1_op)
      OP_LOW: for (int i = 0; i < LANES; i++)
                res_c[i*LANE_W +: LANE_W] = s1_prod[i][LANE_W-1:0];
      OP_HIS, OP_HIU:
              for (int i = 0; i < LANES; i++)
                res_c[i*LANE_W +: LANE_W] = s1_prod[i][2*LANE_W-1:LANE_W];
      OP_MADD: for (int j = 0; j < LANES/2; j++)
                res_c[j*2*LANE_W +: 2*LANE_W] =
                  s1_prod[2*j][2*LANE_W-1:0] + s1_prod[2*j+1][2*LANE_W-1:0];
      OP_SAD: res_c[SAD_W-1:0] = sad_total;
      default: res_c = '0;
    endcase
  end

  // stage 2 registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (advance) begin
      out_valid <= s1_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (advance && s1_valid) out_data <= res_c;
  end

  // R8
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R8
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  // R7
  fill_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  // R7
  valid_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance && s1_valid |=> out_valid);
  // R5
  sad_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance && s1_valid && s1_op == OP_SAD |=> out_data[DATA_W-1:SAD_W] == '0);
endmodule

// File: tb/pmul_sad_unit_test.sv
`timescale 1ns/1ps
module pmul_sad_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [63:0] in_a = '0, in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [63:0] exp_q [$];
  logic [2:0]  op_q  [$];
  bit          prev_stall = 0;
  logic [63:0] prev_data;

  always #5 clk = ~clk;

  pmul_sad_unit uut (.*);

  function automatic string req_of(logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [63:0] model(logic [2:0] op, logic [63:0] a, logic [63:0] b);
    logic [63:0] r = '0;
    longint pr, s;
    int tot = 0;
    for (int i = 0; i < 4; i++) begin
      longint sa = longint'($signed(a[i*16 +: 16]));
      longint sb = longint'($signed(b[i*16 +: 16]));
      longint ua = longint'(a[i*16 +: 16]);
      longint ub = longint'(b[i*16 +: 16]);
      case (op)
        3'd0: begin pr = sa * sb; r[i*16 +: 16] = pr[15:0]; end
        3'd1: begin pr = sa * sb; r[i*16 +: 16] = pr[31:16]; end
        3'd2: begin pr = ua * ub; r[i*16 +: 16] = pr[31:16]; end
        default: ;
      endcase
    end
    if (op == 3'd3) begin
      for (int j = 0; j < 2; j++) begin
        s = longint'($signed(a[j*32 +: 16])) * longint'($signed(b[j*32 +: 16]))
          + longint'($signed(a[j*32+16 +: 16])) * longint'($signed(b[j*32+16 +: 16]));
        r[j*32 +: 32] = s[31:0];
      end
    end
    if (op == 3'd4) begin
      for (int k = 0; k < 8; k++) begin
        int x = int'(a[k*8 +: 8]);
        int y = int'(b[k*8 +: 8]);
        tot += (x > y) ? x - y : y - x;
      end
      r = 64'(tot);
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(bit v, logic [2:0] op, logic [63:0] a, logic [63:0] b, bit rdy);
    @(negedge clk);
    in_valid = v; in_op = op; in_a = a; in_b = b; out_ready = rdy;
    #1;
    if (prev_stall) begin
      // R8: held result stays valid and unchanged
      check(out_valid === 1'b1 && out_data === prev_data, "R8", out_data, prev_data);
    end
    if (out_valid && !out_ready) begin
      // R8: no intake while stalled
      check(in_ready === 1'b0, "R8", 64'(in_ready), 64'd0);
      prev_stall = 1; prev_data = out_data;
    end else prev_stall = 0;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check(0, "R7", out_data, 64'hx);
      else begin
        logic [63:0] e = exp_q.pop_front();
        logic [2:0]  o = op_q.pop_front();
        check(out_data === e, req_of(o), out_data, e);
      end
    end
    if (in_valid && in_ready) begin
      exp_q.push_back(model(op, a, b));
      op_q.push_back(op);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 1);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R9 during and after reset
    repeat (3) @(negedge clk);
    #1 check(out_valid === 1'b0, "R9", 64'(out_valid), 64'd0);
    @(negedge clk); rst_n = 1;
    #1 check(out_valid === 1'b0, "R9", 64'(out_valid), 64'd0);
    cyc(0, 0, 0, 0, 1);
    #1 check(out_valid === 1'b0, "R9", 64'(out_valid), 64'd0);

    // R7 latency of two edges
    cyc(1, 3'd0, 64'h0003_0002_FFFF_7FFF, 64'h0005_0004_FFFF_7FFF, 1);
    cyc(0, 0, 0, 0, 1);
    check(out_valid === 1'b0, "R7", 64'(out_valid), 64'd0);
    cyc(0, 0, 0, 0, 1);
    drain();

    // directed corners
    cyc(1, 3'd1, 64'h8000_8000_7FFF_FFFF, 64'h8000_7FFF_7FFF_FFFF, 1); // R2
    cyc(1, 3'd2, 64'hFFFF_8000_0001_FFFF, 64'hFFFF_8000_FFFF_0002, 1); // R3
    cyc(1, 3'd3, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 1); // R4 wrap 0x80000000
    cyc(1, 3'd3, 64'h0002_FFFF_7FFF_0003, 64'h0003_0004_7FFF_FFFE, 1); // R4
    cyc(1, 3'd4, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1);                   // R5 max 2040
    cyc(1, 3'd4, 64'h0010_2030_FF00_0105, 64'h1000_3020_00FF_0501, 1); // R5
    cyc(1, 3'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, 1); // R6
    cyc(1, 3'd7, 64'h1, 64'h2, 1);                                     // R6
    drain();
    check(exp_q.size() == 0, "R7", 64'(exp_q.size()), 64'd0);

    // R7 back-to-back stream
    for (int i = 0; i < 200; i++)
      cyc(1, 3'($urandom_range(0, 7)), {$urandom, $urandom}, {$urandom, $urandom}, 1);
    drain();
    check(exp_q.size() == 0, "R7", 64'(exp_q.size()), 64'd0);

    // R8 random back-pressure with mixed operations
    for (int i = 0; i < 2000; i++)
      cyc(($urandom_range(0, 3) != 0), 3'($urandom_range(0, 7)),
          {$urandom, $urandom}, {$urandom, $urandom}, ($urandom_range(0, 2) != 0));
    drain();
    check(exp_q.size() == 0, "R8", 64'(exp_q.size()), 64'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule